// File: doc/BRIEF.md
# Eye-Opening Lock Monitor

This block qualifies a serial link's lock status from measured eye openings. After the CDR reports lock and the equalizer adaptation reports completion, it waits a programmable number of base periods. It then asks an external eye-scan engine for a horizontal and a vertical opening measurement. Each result is a count from 0 to 63 steps, carried in an 8-bit field. For the horizontal result, 64 phase steps make one unit interval.

Every result is compared against two pairs of 4-bit thresholds, and each threshold is multiplied by four before the compare. The lock pair decides the registered lock-qualified output. The interrupt pair produces a one-cycle event toward the interrupt logic. Software can also trigger a single measurement, provided an override bit allows it. If CDR lock is lost, the block returns to its quiet state.

The base period of the hardware is 6.5 ms and is obtained by dividing the system clock by `TICK_DIV`. An interval count of 10 therefore gives one check every 65 ms.

Top module: `eyemon_lock_qual`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `meas_req`, `lock_qual` and `thr_event` are 0.
- R2: When `cdr_locked`, `adapt_done` and `mon_en` are all high and no measurement is outstanding, `meas_req` rises on the (TICK_DIV × N)-th rising edge at which all three are sampled high. N is `interval_cnt`, and a value of 0 is treated as 1.
- R3: No periodic request is made unless all three arming inputs are high. Dropping `adapt_done` or `mon_en` discards the partial count, so a later rearm waits the full period again.
- R4: Once raised, `meas_req` stays high until `meas_done` is sampled high, and it is low from the following cycle.
- R5: On the edge at which `meas_done` is sampled with `meas_req` high, `lock_qual` becomes 1 if `heo_val` ≥ 4·`heo_lock_th` and `veo_val` ≥ 4·`veo_lock_th`, and becomes 0 otherwise. Between results it holds its value while lock lasts.
- R6: At a result, if `heo_val` < 4·`heo_irq_th` or `veo_val` < 4·`veo_irq_th` and the event is armed, `thr_event` is high for exactly one cycle and the event disarms. A result with both values at or above their thresholds re-arms it. After reset the event is armed.
- R7: A one-cycle `acq_kick` sampled together with `acq_override` = 1 and `cdr_locked` = 1 raises `meas_req` on the second following edge, whether or not monitoring is armed. The request is consumed once. `acq_kick` with `acq_override` = 0 is ignored.
- R8: With `cdr_locked` low, on the next edge `meas_req` and `lock_qual` are 0, a pending software acquire is dropped, and the interval count restarts.
- R9: After each result the interval count restarts from zero, so the next periodic request follows TICK_DIV × N edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cdr_locked | input | 1 | CDR lock status |
| adapt_done | input | 1 | Equalizer adaptation complete |
| mon_en | input | 1 | Periodic monitoring enable |
| interval_cnt | input | CNT_W | Number of base periods between checks (0 acts as 1) |
| heo_lock_th | input | THR_W | Horizontal lock threshold, multiplied by four |
| veo_lock_th | input | THR_W | Vertical lock threshold, multiplied by four |
| heo_irq_th | input | THR_W | Horizontal event threshold, multiplied by four |
| veo_irq_th | input | THR_W | Vertical event threshold, multiplied by four |
| acq_override | input | 1 | Allows software-triggered measurements |
| acq_kick | input | 1 | One-shot acquire strobe |
| meas_done | input | 1 | Measurement finished; results valid |
| heo_val | input | VAL_W | Horizontal eye opening result |
| veo_val | input | VAL_W | Vertical eye opening result |
| meas_req | output | 1 | Measurement request, held until done |
| lock_qual | output | 1 | Eye-qualified lock |
| thr_event | output | 1 | One-cycle threshold event |

## Verification
All three outputs are registered. `lock_qual` and `thr_event` change on the edge that samples `meas_done`. A periodic `meas_req` appears on the TICK_DIV × N-th armed edge, a software acquire takes two edges, and loss of lock takes one edge. The bench drives inputs and samples outputs on the falling clock edge. A behavioural model advances on the same rising edges and is compared against the outputs every cycle. Directed checks count exactly those edges, checking one cycle before each due point and again at it.

// File: rtl/eyemon_pkg.sv
package eyemon_pkg;
  typedef enum logic {
    MON_IDLE = 1'b0,
    MON_WAIT = 1'b1
  } mon_state_e;

  // Threshold nibbles are scaled by 2**THR_SHIFT before comparison.
  localparam int THR_SHIFT = 2;
endpackage

// File: rtl/eyemon_tick_div.sv
module eyemon_tick_div #(
  parameter int TICK_DIV = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(TICK_DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  // Any cycle without run discards the partial base period.
  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/eyemon_interval.sv
module eyemon_interval #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  localparam int EW = CNT_W + 1;

  logic [CNT_W-1:0] iv_q;
  logic [EW-1:0]    lim_eff;
  logic [EW-1:0]    iv_next;

  assign lim_eff = (limit == '0) ? EW'(1) : {1'b0, limit};
  assign iv_next = {1'b0, iv_q} + EW'(1);
  // >= keeps the counter from running past a lowered limit.
  assign expire  = tick && (iv_next >= lim_eff);

  always_ff @(posedge clk) begin
    if (rst || !run)
      iv_q <= '0;
    else if (expire)
      iv_q <= '0;
    else if (tick)
      iv_q <= iv_q + 1'b1;
  end
endmodule

// File: rtl/eyemon_eval.sv
module eyemon_eval
  import eyemon_pkg::*;
#(
  parameter int VAL_W = 8,
  parameter int THR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             unlock,
  input  logic             capture,
  input  logic [VAL_W-1:0] heo,
  input  logic [VAL_W-1:0] veo,
  input  logic [THR_W-1:0] heo_lock_th,
  input  logic [THR_W-1:0] veo_lock_th,
  input  logic [THR_W-1:0] heo_irq_th,
  input  logic [THR_W-1:0] veo_irq_th,
  output logic             lock_q,
  output logic             evt_q
);
  localparam int SW = THR_W + THR_SHIFT;
  localparam int CW = (VAL_W > SW) ? VAL_W : SW;
  localparam int NAX = 2;

  logic [VAL_W-1:0] val_a  [NAX];
  logic [THR_W-1:0] lth_a  [NAX];
  logic [THR_W-1:0] ith_a  [NAX];
  logic [NAX-1:0]   meets;
  logic [NAX-1:0]   under;
  logic             arm_q;

  assign val_a[0] = heo;
  assign val_a[1] = veo;
  assign lth_a[0] = heo_lock_th;
  assign lth_a[1] = veo_lock_th;
  assign ith_a[0] = heo_irq_th;
  assign ith_a[1] = veo_irq_th;

  // Axis 0 is horizontal, axis 1 vertical; both compare the same way.
  for (genvar g = 0; g < NAX; g++) begin : g_axis
    logic [CW-1:0] v_ext;
    logic [CW-1:0] l_ext;
    logic [CW-1:0] i_ext;
    assign v_ext    = CW'(val_a[g]);
    assign l_ext    = CW'({lth_a[g], {THR_SHIFT{1'b0}}});
    assign i_ext    = CW'({ith_a[g], {THR_SHIFT{1'b0}}});
    assign meets[g] = (v_ext >= l_ext);
    assign under[g] = (v_ext <  i_ext);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      evt_q  <= 1'b0;
      arm_q  <= 1'b1;
    end else begin
      evt_q <= 1'b0;
      if (unlock) begin
        lock_q <= 1'b0;
      end else if (capture) begin
        lock_q <= &meets;
        if (|under) begin
          if (arm_q) evt_q <= 1'b1;
          arm_q <= 1'b0;
        end else begin
          arm_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/eyemon_lock_qual.sv
module eyemon_lock_qual
  import eyemon_pkg::*;
#(
  parameter int TICK_DIV = 1000,
  parameter int CNT_W    = 4,
  parameter int THR_W    = 4,
  parameter int VAL_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cdr_locked,
  input  logic             adapt_done,
  input  logic             mon_en,
  input  logic [CNT_W-1:0] interval_cnt,
  input  logic [THR_W-1:0] heo_lock_th,
  input  logic [THR_W-1:0] veo_lock_th,
  input  logic [THR_W-1:0] heo_irq_th,
  input  logic [THR_W-1:0] veo_irq_th,
  input  logic             acq_override,
  input  logic             acq_kick,
  input  logic             meas_done,
  input  logic [VAL_W-1:0] heo_val,
  input  logic [VAL_W-1:0] veo_val,
  output logic             meas_req,
  output logic             lock_qual,
  output logic             thr_event
);
  mon_state_e state_q;
  logic       acq_pend_q;
  logic       idle;
  logic       armed;
  logic       run;
  logic       tick;
  logic       expire;
  logic       capture;

  assign idle    = (state_q == MON_IDLE);
  assign armed   = cdr_locked && adapt_done && mon_en;
  // A pending acquire takes precedence and restarts the period.
  assign run     = armed && idle && !acq_pend_q;
  assign capture = !idle && meas_done && cdr_locked;

  eyemon_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick)
  );

  eyemon_interval #(.CNT_W(CNT_W)) u_ivl (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .tick   (tick),
    .limit  (interval_cnt),
    .expire (expire)
  );

  always_ff @(posedge clk) begin
    if (rst || !cdr_locked) begin
      state_q    <= MON_IDLE;
      acq_pend_q <= 1'b0;
    end else begin
      case (state_q)
        MON_IDLE: if (acq_pend_q || expire) state_q <= MON_WAIT;
        MON_WAIT: if (meas_done) state_q <= MON_IDLE;
        default:  state_q <= MON_IDLE;
      endcase
      if (acq_kick && acq_override)
        acq_pend_q <= 1'b1;
      else if (idle && acq_pend_q)
        acq_pend_q <= 1'b0;
    end
  end

  assign meas_req = (state_q == MON_WAIT);

  eyemon_eval #(.VAL_W(VAL_W), .THR_W(THR_W)) u_eval (
    .clk         (clk),
    .rst         (rst),
    .unlock      (!cdr_locked),
    .capture     (capture),
    .heo         (heo_val),
    .veo         (veo_val),
    .heo_lock_th (heo_lock_th),
    .veo_lock_th (veo_lock_th),
    .heo_irq_th  (heo_irq_th),
    .veo_irq_th  (veo_irq_th),
    .lock_q      (lock_qual),
    .evt_q       (thr_event)
  );
endmodule

// File: rtl/eyemon_lock_qual_chk.sv
module eyemon_lock_qual_chk (
  input logic clk,
  input logic rst,
  input logic cdr_locked,
  input logic meas_req,
  input logic meas_done,
  input logic lock_qual,
  input logic thr_event
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!meas_req && !lock_qual && !thr_event));

  p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (meas_req && !meas_done && cdr_locked) |=> meas_req);

  p_req_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (meas_req && meas_done) |=> !meas_req);

  p_lock_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (!(meas_req && meas_done) && cdr_locked) |=> $stable(lock_qual));

  p_evt_single_r6: assert property (@(posedge clk) disable iff (rst)
    thr_event |=> !thr_event);

  p_evt_cause_r6: assert property (@(posedge clk) disable iff (rst)
    thr_event |-> $past(meas_req && meas_done && cdr_locked));

  p_unlock_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !cdr_locked |=> (!meas_req && !lock_qual));

  p_req_locked_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(meas_req) |-> $past(cdr_locked));
endmodule

bind eyemon_lock_qual eyemon_lock_qual_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cdr_locked (cdr_locked),
  .meas_req   (meas_req),
  .meas_done  (meas_done),
  .lock_qual  (lock_qual),
  .thr_event  (thr_event)
);

// File: tb/sim_eyemon_lock_qual.sv
module sim_eyemon_lock_qual;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 4;
  localparam int LAT  = 3;
  localparam int WDOG = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cdr = 1'b0, adapt = 1'b0, mon_en = 1'b0;
  logic [3:0] ivl = 4'd2;
  logic [3:0] hl = 4'd4, vl = 4'd4, hi = 4'd2, vi = 4'd2;
  logic acq_ovr = 1'b0, acq_set = 1'b0;
  logic meas_done = 1'b0;
  logic [7:0] heo_val = 8'd0, veo_val = 8'd0;
  logic [7:0] heo_next = 8'd40, veo_next = 8'd40;
  logic meas_req, lock_qual, thr_event;

  int checks = 0;
  int failures = 0;
  bit done_flag = 0;

  // behavioural reference state
  bit m_busy, m_pend, m_lock, m_arm, m_evt;
  int m_cnt;
  int eng_wait = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eyemon_lock_qual #(.TICK_DIV(TDIV)) u0 (
    .clk(clk), .rst(rst), .cdr_locked(cdr), .adapt_done(adapt), .mon_en(mon_en),
    .interval_cnt(ivl), .heo_lock_th(hl), .veo_lock_th(vl),
    .heo_irq_th(hi), .veo_irq_th(vi), .acq_override(acq_ovr), .acq_kick(acq_set),
    .meas_done(meas_done), .heo_val(heo_val), .veo_val(veo_val),
    .meas_req(meas_req), .lock_qual(lock_qual), .thr_event(thr_event)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model, advanced on the same edges as the design.
  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_pend = 0; m_lock = 0; m_arm = 1; m_evt = 0; m_cnt = 0;
    end else begin
      m_evt = 0;
      if (!cdr) begin
        m_busy = 0; m_cnt = 0; m_pend = 0; m_lock = 0;
      end else begin
        int nn;
        bit below;
        nn = (ivl == 0) ? 1 : int'(ivl);
        if (m_busy) begin
          if (meas_done) begin
            m_busy = 0; m_cnt = 0;
            m_lock = (int'(heo_val) >= 4*hl) && (int'(veo_val) >= 4*vl);
            below = (int'(heo_val) < 4*hi) || (int'(veo_val) < 4*vi);
            if (below && m_arm) begin m_evt = 1; m_arm = 0; end
            else if (!below) m_arm = 1;
          end
        end else if (m_pend) begin
          m_busy = 1; m_cnt = 0; m_pend = 0;
        end else if (adapt && mon_en) begin
          m_cnt++;
          if (m_cnt >= TDIV*nn) begin m_busy = 1; m_cnt = 0; end
        end else begin
          m_cnt = 0;
        end
        if (acq_set && acq_ovr) m_pend = 1;
      end
    end
  end

  // Per-cycle comparison and eye-scan engine model.
  always @(negedge clk) begin
    if (!rst) begin
      check("R4 meas_req vs model", meas_req, m_busy);
      check("R5 lock_qual vs model", lock_qual, m_lock);
      check("R6 thr_event vs model", thr_event, m_evt);
    end
    if (meas_done) begin
      meas_done = 1'b0;
    end else if (meas_req) begin
      if (eng_wait == LAT-1) begin
        meas_done = 1'b1; heo_val = heo_next; veo_val = veo_next; eng_wait = 0;
      end else eng_wait++;
    end else eng_wait = 0;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_result();
    do @(posedge clk); while (!meas_done);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(4);
    check("R1 meas_req in reset", meas_req, 0);
    check("R1 lock_qual in reset", lock_qual, 0);
    check("R1 thr_event in reset", thr_event, 0);
    rst = 1'b0;
    cyc(1);
    check("R1 lock_qual after reset", lock_qual, 0);

    // R2: first periodic request at TDIV*2 armed edges
    cdr = 1; adapt = 1; mon_en = 1;
    cyc(TDIV*2 - 1);
    check("R2 no request before period", meas_req, 0);
    cyc(1);
    check("R2 request at period", meas_req, 1);
    cyc(1);
    check("R4 request held until done", meas_req, 1);
    wait_result();
    check("R4 request dropped after done", meas_req, 0);
    check("R5 good eye qualifies lock", lock_qual, 1);
    check("R6 no event above threshold", thr_event, 0);

    // R6: event on drop, single pulse, no repeat, re-arm
    heo_next = 8'd5;
    wait_result();
    check("R6 event on low horizontal", thr_event, 1);
    check("R5 low eye clears lock", lock_qual, 0);
    cyc(1);
    check("R6 event lasts one cycle", thr_event, 0);
    wait_result();
    check("R6 no repeat while disarmed", thr_event, 0);
    heo_next = 8'd40;
    wait_result();
    check("R5 lock restored", lock_qual, 1);
    check("R6 re-arm result gives no event", thr_event, 0);
    veo_next = 8'd6;
    wait_result();
    check("R6 event after re-arm", thr_event, 1);
    veo_next = 8'd40;
    wait_result();

    // R3: arming inputs
    mon_en = 0;
    cyc(30);
    check("R3 no request with monitor disabled", meas_req, 0);
    mon_en = 1; adapt = 0;
    cyc(30);
    check("R3 no request before adaptation", meas_req, 0);
    adapt = 1;
    cyc(TDIV*2 - 1);
    check("R3 full period after rearm", meas_req, 0);
    cyc(1);
    check("R3 request after rearm", meas_req, 1);
    wait_result();

    // R7: software acquire
    mon_en = 0; acq_ovr = 0; acq_set = 1;
    cyc(1);
    acq_set = 0;
    cyc(4);
    check("R7 kick ignored without override", meas_req, 0);
    acq_ovr = 1; acq_set = 1;
    cyc(1);
    acq_set = 0;
    check("R7 no request one edge after kick", meas_req, 0);
    cyc(1);
    check("R7 request two edges after kick", meas_req, 1);
    wait_result();
    cyc(4);
    check("R7 acquire consumed once", meas_req, 0);
    check("R5 acquire result qualifies lock", lock_qual, 1);

    // R8: loss of lock aborts request and clears lock
    mon_en = 1;
    do @(negedge clk); while (!meas_req);
    cdr = 0;
    cyc(1);
    check("R8 request aborted on unlock", meas_req, 0);
    check("R8 lock cleared on unlock", lock_qual, 0);
    mon_en = 0; cdr = 1; acq_set = 1;
    cyc(1);
    acq_set = 0; cdr = 0;
    cyc(1);
    cdr = 1;
    cyc(5);
    check("R8 pending acquire dropped", meas_req, 0);

    // R9: restart after result, interval 0 acts as 1
    ivl = 4'd0; mon_en = 1;
    wait_result();
    cyc(TDIV - 1);
    check("R9 no request before restarted period", meas_req, 0);
    cyc(1);
    check("R9 request one base period after result", meas_req, 1);
    wait_result();
    cyc(2);

    finish_run();
  end
endmodule